// File: doc/BRIEF.md
# Wakeup Interrupt Forwarding Controller

This block sits between a bank of raw interrupt sources and a downstream interrupt controller that only understands rising edges and active-high levels. Each pin has its own configuration word that selects a trigger type, enables the pin, masks it and holds a sticky latched-event flag. Every pin input passes through a two-flop synchroniser. The block then inverts active-low and falling-edge sources, so the downstream side never sees a low-going request.

The pins are split into two ranges. The lower indices are direct lines and the upper indices are GPIO-derived lines. A global mode register selects one of two modes. In pass-through mode every pin is forwarded without any latching. In secondary mode the GPIO-range pins instead capture qualifying events into their sticky status bits and drive a level-high output until software clears the bit. Direct pins keep the pass-through behaviour in both modes.

Software reaches the block through a word-addressed port. The address is the pin index. The mode register sits at one fixed address above the pin range, and reads are combinational.

Top module: `wkf_forwarder`

## Requirements
- R1: After reset every configuration word and the mode register read as 0, and every output is low.
- R2: A pin's configuration word is read and written at address = pin index. Its bits are: [2:0] trigger type, [3] enable, [4] mask, [5] latched status. Bits above 5 read as 0, and any unused address reads as 0.
- R3: Bit 0 of the mode register, at address MODE_ADDR, selects the mode: 0 for pass-through and 1 for secondary.
- R4: In pass-through, an enabled pin with a level trigger drives its output equal to the synchronised input, two clock edges after the input changes. Type 4 is level high and is not inverted. Type 0 is level low and is inverted. Types 5 to 7 behave as level high.
- R5: In pass-through, an enabled edge-type pin drives a one-cycle pulse for each qualifying synchronised edge. Type 1 responds to falling edges, type 2 to rising edges and type 3 to both.
- R6: A pin whose enable bit is 0 drives its output low while it is not presenting a latched status.
- R7: Pins below NUM_DIRECT behave as in R4 and R5 in both modes and never set their status bit.
- R8: In secondary mode, a qualifying event on an enabled GPIO-range pin sets its status bit on the next edge. The output is then high for as long as status is 1 and mask is 0.
- R9: A mask of 1 holds a latched GPIO output low without clearing status. Clearing the mask restores the output.
- R10: Writing status as 0 clears it, and writing status as 1 leaves it unchanged. If an event occurs in the same cycle as a clear, the status stays set.
- R11: The status bit is never set while the pin is disabled or while the mode is pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | NUM_DIRECT+NUM_GPIO | Raw interrupt sources; direct pins first, then GPIO pins |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register word address |
| wr_data_i | input | DATA_W | Register write data |
| rd_data_o | output | DATA_W | Combinational read data for addr_i |
| irq_o | output | NUM_DIRECT+NUM_GPIO | Normalised requests to the downstream controller |

## Verification
The assertions check four properties on every cycle. A latched status survives every cycle except one with an explicit clear. Status never appears on a disabled pin or outside secondary mode. A masked GPIO output stays low. A rising-edge pulse in pass-through lasts exactly one cycle. Only the bench scenarios, checked against a cycle model, can show the rest: synchroniser latency, polarity inversion for each trigger code, the clear-versus-event collision, mode switches while status is held, and direct pins that ignore secondary mode.

// File: rtl/wkf_pkg.sv
package wkf_pkg;

    localparam int CFG_W = 6;

    localparam logic [2:0] TRIG_LVL_LO = 3'd0;
    localparam logic [2:0] TRIG_FALL   = 3'd1;
    localparam logic [2:0] TRIG_RISE   = 3'd2;
    localparam logic [2:0] TRIG_BOTH   = 3'd3;
    localparam logic [2:0] TRIG_LVL_HI = 3'd4;

    // Field order matches the register word: status[5] mask[4] en[3] trig[2:0]
    typedef struct packed {
        logic       status;
        logic       mask;
        logic       en;
        logic [2:0] trig;
    } pin_cfg_t;

    typedef struct packed {
        pin_cfg_t cfg;
        logic     prev;
    } pin_state_t;

endpackage

// File: rtl/wkf_sync.sv
module wkf_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[g] <= '0;
            else         stage_q[g] <= stage_d[g];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/wkf_pin.sv
module wkf_pin
    import wkf_pkg::*;
#(
    parameter bit IS_GPIO = 1'b0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sync_i,
    input  logic             sec_mode_i,
    input  logic             wr_i,
    input  logic [CFG_W-1:0] wr_data_i,
    output pin_cfg_t         cfg_o,
    output logic             irq_o
);

    pin_state_t st_d, st_q;
    logic       sec_gpio;
    logic       evt;
    logic       set_evt;
    pin_cfg_t   wr_cfg;

    assign sec_gpio = sec_mode_i && IS_GPIO;
    assign wr_cfg   = pin_cfg_t'(wr_data_i);

    always_comb begin
        unique case (st_q.cfg.trig)
            TRIG_LVL_LO: evt = !sync_i;
            TRIG_FALL:   evt = st_q.prev && !sync_i;
            TRIG_RISE:   evt = !st_q.prev && sync_i;
            TRIG_BOTH:   evt = st_q.prev ^ sync_i;
            default:     evt = sync_i;
        endcase

        set_evt = sec_gpio && st_q.cfg.en && evt;

        st_d      = st_q;
        st_d.prev = sync_i;
        if (wr_i) begin
            st_d.cfg        = wr_cfg;
            st_d.cfg.status = (st_q.cfg.status && wr_cfg.status) || set_evt;
        end else begin
            st_d.cfg.status = st_q.cfg.status || set_evt;
        end

        if (sec_gpio) irq_o = st_q.cfg.status && !st_q.cfg.mask;
        else          irq_o = st_q.cfg.en && evt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cfg_o = st_q.cfg;

    // R10: status is sticky until an explicit clear write
    a_r10_status_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cfg.status && !(wr_i && !wr_cfg.status) |=> st_q.cfg.status);

    // R11: no latch on a disabled pin
    a_r11_no_set_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.cfg.status && !st_q.cfg.en |=> !st_q.cfg.status);

    // R11 / R7: no latch outside secondary mode or on direct pins
    a_r11_no_set_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.cfg.status && !sec_gpio |=> !st_q.cfg.status);

    // R9: a masked latched output stays low
    a_r9_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sec_gpio && st_q.cfg.mask |-> !irq_o);

    // R5: a rising-edge pulse lasts one cycle
    a_r5_pulse_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sec_gpio && st_q.cfg.trig == TRIG_RISE && irq_o && !wr_i
        |=> !irq_o || sec_gpio);

endmodule

// File: rtl/wkf_forwarder.sv
module wkf_forwarder
    import wkf_pkg::*;
#(
    parameter int NUM_DIRECT = 4,
    parameter int NUM_GPIO   = 4,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int MODE_ADDR  = (1 << ADDR_W) - 1
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic [NUM_DIRECT+NUM_GPIO-1:0] irq_i,
    input  logic                           wr_en_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [DATA_W-1:0]              wr_data_i,
    output logic [DATA_W-1:0]              rd_data_o,
    output logic [NUM_DIRECT+NUM_GPIO-1:0] irq_o
);

    localparam int NUM_PINS = NUM_DIRECT + NUM_GPIO;
    localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_ADDR);

    typedef struct packed {
        logic sec_mode;
    } top_state_t;

    top_state_t            top_d, top_q;
    logic [NUM_PINS-1:0]   irq_sync;
    logic [NUM_PINS-1:0]   pin_wr;
    pin_cfg_t              pin_cfg [NUM_PINS];
    logic                  mode_wr;
    logic                  unused_wr_hi;

    assign unused_wr_hi = ^wr_data_i[DATA_W-1:CFG_W];

    wkf_sync #(.WIDTH(NUM_PINS), .STAGES(2)) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(irq_i),
        .sync_o (irq_sync)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign pin_wr[p] = wr_en_i && (addr_i == ADDR_W'(p));
        wkf_pin #(.IS_GPIO(p >= NUM_DIRECT)) i_pin (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .sync_i    (irq_sync[p]),
            .sec_mode_i(top_q.sec_mode),
            .wr_i      (pin_wr[p]),
            .wr_data_i (wr_data_i[CFG_W-1:0]),
            .cfg_o     (pin_cfg[p]),
            .irq_o     (irq_o[p])
        );
    end

    assign mode_wr = wr_en_i && (addr_i == MODE_A);

    always_comb begin
        top_d = top_q;
        if (mode_wr) top_d.sec_mode = wr_data_i[0];

        rd_data_o = '0;
        if (addr_i == MODE_A) rd_data_o[0] = top_q.sec_mode;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (addr_i == ADDR_W'(p)) rd_data_o[CFG_W-1:0] = pin_cfg[p];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) top_q <= '0;
        else         top_q <= top_d;
    end

    // R3: mode register takes bit 0 of a write to its address
    a_r3_mode_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_wr |=> top_q.sec_mode == $past(wr_data_i[0]));

    // R3: mode holds without a write
    a_r3_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mode_wr |=> $stable(top_q.sec_mode));

endmodule

// File: tb/test_wkf_forwarder.sv
module test_wkf_forwarder;

    localparam int ND = 4;
    localparam int NG = 4;
    localparam int NP = ND + NG;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam logic [AW-1:0] MODE_A = 8'hFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] irq_in = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [NP-1:0] irq_out;

    always #10 clk = ~clk;

    wkf_forwarder #(.NUM_DIRECT(ND), .NUM_GPIO(NG), .ADDR_W(AW), .DATA_W(DW))
    i_wkf_forwarder (
        .clk_i(clk), .rst_ni(rst_n), .irq_i(irq_in), .wr_en_i(wr_en),
        .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata), .irq_o(irq_out)
    );

    int    n_vec = 0;
    int    n_err = 0;
    int    cycles = 0;
    string tag = "R1";

    // reference model
    logic       m_s1 [NP];
    logic       m_s2 [NP];
    logic       m_prev [NP];
    logic [5:0] m_cfg [NP];
    logic       m_mode;

    function automatic logic f_evt(logic [2:0] t, logic s, logic pv);
        case (t)
            3'd0:    return !s;
            3'd1:    return pv && !s;
            3'd2:    return !pv && s;
            3'd3:    return pv ^ s;
            default: return s;
        endcase
    endfunction

    function automatic logic [NP-1:0] f_out();
        logic [NP-1:0] o;
        for (int p = 0; p < NP; p++) begin
            if (m_mode && p >= ND) o[p] = m_cfg[p][5] && !m_cfg[p][4];
            else                   o[p] = m_cfg[p][3] && f_evt(m_cfg[p][2:0], m_s2[p], m_prev[p]);
        end
        return o;
    endfunction

    function automatic logic [DW-1:0] f_rd(logic [AW-1:0] a);
        if (a == MODE_A) return {{(DW-1){1'b0}}, m_mode};
        if (int'(a) < NP) return {{(DW-6){1'b0}}, m_cfg[int'(a)]};
        return '0;
    endfunction

    task automatic model_reset();
        for (int p = 0; p < NP; p++) begin
            m_s1[p] = 0; m_s2[p] = 0; m_prev[p] = 0; m_cfg[p] = '0;
        end
        m_mode = 0;
    endtask

    task automatic model_update();
        for (int p = 0; p < NP; p++) begin
            logic st;
            logic set;
            set = m_mode && p >= ND && m_cfg[p][3] &&
                  f_evt(m_cfg[p][2:0], m_s2[p], m_prev[p]);
            if (wr_en && int'(addr) == p) begin
                st = (m_cfg[p][5] && wdata[5]) || set;
                m_cfg[p] = {st, wdata[4:0]};
            end else begin
                m_cfg[p][5] = m_cfg[p][5] || set;
            end
            m_prev[p] = m_s2[p];
            m_s2[p]   = m_s1[p];
            m_s1[p]   = irq_in[p];
        end
        if (wr_en && addr == MODE_A) m_mode = wdata[0];
    endtask

    task automatic compare();
        logic [NP-1:0] eo;
        logic [DW-1:0] er;
        eo = f_out();
        er = f_rd(addr);
        n_vec++;
        if (irq_out !== eo) begin
            n_err++;
            $display("FAIL %s irq_o act=%h exp=%h t=%0t", tag, irq_out, eo, $time);
        end
        n_vec++;
        if (rdata !== er) begin
            n_err++;
            $display("FAIL %s rd_data addr=%h act=%h exp=%h t=%0t", tag, addr, rdata, er, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        model_update();
        @(negedge clk);
        compare();
        wr_en = 1'b0;
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(logic [AW-1:0] a, logic [5:0] d);
        wr_en = 1'b1; addr = a; wdata = {{(DW-6){1'b0}}, d};
        step();
        addr = a;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        tag = "R1";
        compare();
        addr = MODE_A; #1 compare();
        addr = 8'd5;   #1 compare();

        // R2: field layout readback; a written status 1 does not set status
        tag = "R2";
        wr(8'd0, 6'h3A);
        steps(1);
        addr = 8'h40; steps(1);

        // R4: level low on pin 0 (inverted), level high on pin 3, code 6 on pin 2
        tag = "R4";
        wr(8'd0, 6'h08);
        wr(8'd3, 6'h0C);
        wr(8'd2, 6'h0E);
        steps(3);
        irq_in[3] = 1; irq_in[0] = 1; irq_in[2] = 1; steps(3);
        irq_in[0] = 0; irq_in[2] = 0; steps(3);

        // R5: rising, falling, both edges on pins 1..3
        tag = "R5";
        wr(8'd1, 6'h0A);
        wr(8'd2, 6'h09);
        wr(8'd3, 6'h0B);
        irq_in[1] = 1; irq_in[2] = 1; irq_in[3] = 0; steps(4);
        irq_in[1] = 0; irq_in[2] = 0; irq_in[3] = 1; steps(4);

        // R6: disabled level-high pin stays low
        tag = "R6";
        wr(8'd0, 6'h04);
        irq_in[0] = 1; steps(4);

        // R3 + R8: secondary mode, rising edge latched on GPIO pin 5
        tag = "R3";
        wr(MODE_A, 6'h01);
        steps(1);
        tag = "R8";
        wr(8'd5, 6'h0A);
        irq_in[5] = 1; steps(2);
        irq_in[5] = 0; steps(4);

        // R9: mask holds status but silences output, then unmask
        tag = "R9";
        wr(8'd5, 6'h3A); steps(2);
        wr(8'd5, 6'h2A); steps(2);

        // R10: clear by writing 0, then collision with a live level event
        tag = "R10";
        wr(8'd5, 6'h0A); steps(2);
        wr(8'd6, 6'h0C);
        irq_in[6] = 1; steps(4);
        wr(8'd6, 6'h0C); steps(2);
        irq_in[6] = 0; steps(3);
        wr(8'd6, 6'h0C); steps(2);

        // R7: direct pin 1 still pulses and never latches in secondary mode
        tag = "R7";
        wr(8'd1, 6'h0A);
        irq_in[1] = 1; steps(4);
        addr = 8'd1; steps(1);

        // R11: disabled GPIO pin in secondary mode, and pass-through GPIO
        tag = "R11";
        wr(8'd7, 6'h04);
        irq_in[7] = 1; steps(4);
        wr(MODE_A, 6'h00);
        wr(8'd4, 6'h0C);
        irq_in[4] = 1; steps(4);
        addr = 8'd4; steps(1);

        // random mix
        tag = "R4/R8";
        for (int i = 0; i < 4000; i++) begin
            for (int p = 0; p < NP; p++)
                if ($urandom_range(3) == 0) irq_in[p] = ~irq_in[p];
            if ($urandom_range(63) == 0) begin
                wr_en = 1; addr = MODE_A; wdata = {31'b0, ~m_mode};
            end else if ($urandom_range(11) == 0) begin
                int pp;
                pp = $urandom_range(NP-1);
                wr_en = 1; addr = AW'(pp);
                wdata = {{(DW-6){1'b0}}, 6'($urandom())};
            end else begin
                addr = ($urandom_range(8) == 8) ? MODE_A : AW'($urandom_range(NP-1));
            end
            step();
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule